// File: doc/BRIEF.md
# Extended Interrupt Pending-Clear Register Bank

This block keeps the pending and active state of a bank of shared interrupts in an extended numbering range. Software reaches it through 32-bit clear-pending words on a simple register bus. Local interrupt `i` stands for global interrupt number 4096 + i. A one written into a word drops the software-held pending state of the matching interrupt. A zero does nothing. A read returns the pending state of the word's 32 interrupts. The live pending vector and the active vector go to downstream arbitration logic.

Each interrupt has a trigger mode. A level-sensitive interrupt is pending while its line is high, or while a latched set-pending request is held. An edge-triggered interrupt latches pending on a rising line or on a set-pending pulse. A handler model drives activate and deactivate pulses. Two kinds of masking hide bits: bits of unimplemented interrupts, and bits of secure interrupts seen by a non-secure access while security is not disabled. Masked bits read as zero and ignore writes.

The bus side is a three-state machine. `ST_IDLE` accepts a strobe; a write has priority over a read. Transition IDLE→WR_APPLY on `bus_wr`, IDLE→RD_CAPTURE on `bus_rd` alone. `ST_WR_APPLY` applies the latched clear mask. `ST_RD_CAPTURE` registers the read word. Both return unconditionally to `ST_IDLE`.

Top module: `irq_pend_clear_bank`

## Requirements
- R1: Word n (0 ≤ n < NREG) sits at byte address 0x1800 + 4n; bit x maps to local interrupt 32n + x. Unaligned addresses, addresses outside the window and n ≥ NREG read as 0, and writes to them change nothing.
- R2: An interrupt is implemented only when `ext_enable` is 1 and its word index is ≤ `range_cfg`. Unimplemented interrupts read 0, ignore writes, hold no state, and show 0 on `pending_o` and `active_o`.
- R3: A 0 in a written bit position leaves that interrupt's state unchanged.
- R4: A 1 written to an accessible bit clears the latched pending flag. Pending goes to inactive, and active-and-pending goes to active with `active_o` kept at 1.
- R5: When `irq_level`=1, pending is the latched flag OR `irq_sig`. While `irq_sig` is high the interrupt stays pending through a clear write.
- R6: When `irq_level`=0, a rising `irq_sig` (the value at this edge is 1, the value at the previous edge was 0) or a `set_pulse` sets the latch. For level mode, only `set_pulse` sets it.
- R7: When a set or edge event and an applied clear meet on one interrupt at the same edge, the interrupt stays pending.
- R8: A read accepted at edge k drives `rd_valid_o`=1 for exactly one cycle, after edge k+1. `rd_data_o` then holds the pending bits ANDed with access permission, and it is 0 whenever `rd_valid_o` is 0.
- R9: With `sec_disable`=0 and `bus_secure`=0, bits of interrupts with `irq_secure`=1 read as 0 and ignore writes. Secure accesses, or `sec_disable`=1, reach every implemented bit.
- R10: Reset clears all latched pending, active and edge history, and sets `rd_valid_o` to 0.
- R11: A write accepted at edge k takes effect at edge k+1. Strobes that arrive while the machine is not in `ST_IDLE` are ignored.
- R12: An `act_pulse` on a pending, implemented interrupt sets active and clears the latch (a set event at the same edge wins). `deact_pulse` clears active. Activation has no effect on an interrupt that is not pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data, one clear bit per interrupt |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_secure | input | 1 | Access is secure |
| ext_enable | input | 1 | Extended range present |
| range_cfg | input | 5 | Highest implemented word index |
| sec_disable | input | 1 | Security masking off when 1 |
| irq_level | input | 32*NREG | Trigger mode, 1 = level-sensitive |
| irq_sig | input | 32*NREG | Interrupt lines |
| irq_secure | input | 32*NREG | Interrupt is secure |
| set_pulse | input | 32*NREG | Set-pending pulses |
| act_pulse | input | 32*NREG | Activate pulses |
| deact_pulse | input | 32*NREG | Deactivate pulses |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| pending_o | output | 32*NREG | Pending vector |
| active_o | output | 32*NREG | Active vector |

## Verification
A latch with a wrong value shows on `pending_o` in the cycle after the faulty edge, because the output is a direct function of the latch and the live line. A wrong active flag shows on `active_o` in that same cycle, and later in the result of an activate or clear. A bad decode or a bad mask shows as a wrong bit in `rd_data_o` two edges after the read strobe. A mistaken clear shows as a bit that drops or stays on `pending_o` two edges after the write strobe. The machine state itself shows only through that two-edge spacing and through strobes that get ignored.

// File: rtl/pend_clr_pkg.sv
package pend_clr_pkg;
    localparam int WORD_W    = 32;
    localparam int BANK_BASE = 32'h1800;
    localparam int IDX_W     = 5;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WR_APPLY   = 2'd1,
        ST_RD_CAPTURE = 2'd2
    } bus_state_t;
endpackage

// File: rtl/pend_bus_fsm.sv
module pend_bus_fsm
    import pend_clr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_secure,
    output bus_state_t        state_o,
    output logic [AW-1:0]     lat_addr_o,
    output logic [WORD_W-1:0] lat_data_o,
    output logic              lat_secure_o
);
    bus_state_t state_q, state_d;
    logic       accept;

    assign accept  = (state_q == ST_IDLE) && (bus_wr || bus_rd);
    assign state_o = state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_wr)      state_d = ST_WR_APPLY;
                else if (bus_rd) state_d = ST_RD_CAPTURE;
            end
            ST_WR_APPLY:   state_d = ST_IDLE;
            ST_RD_CAPTURE: state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr_o   <= '0;
            lat_data_o   <= '0;
            lat_secure_o <= 1'b0;
        end else if (accept) begin
            lat_addr_o   <= bus_addr;
            lat_data_o   <= bus_wr ? bus_wdata : '0;
            lat_secure_o <= bus_secure;
        end
    end
endmodule

// File: rtl/pend_decode.sv
module pend_decode
    import pend_clr_pkg::*;
#(
    parameter int NREG = 4,
    parameter int AW   = 16
) (
    input  logic                   apply,
    input  logic [AW-1:0]          lat_addr,
    input  logic [WORD_W-1:0]      lat_data,
    input  logic                   lat_secure,
    input  logic                   ext_enable,
    input  logic [IDX_W-1:0]       range_cfg,
    input  logic                   sec_disable,
    input  logic [NREG*WORD_W-1:0] irq_secure,
    output logic [NREG*WORD_W-1:0] impl_mask,
    output logic [NREG*WORD_W-1:0] access_mask,
    output logic [NREG*WORD_W-1:0] clr_vec,
    output logic                   lat_hit,
    output logic [IDX_W-1:0]       lat_idx
);
    localparam int NIRQ   = NREG * WORD_W;
    localparam int HI_W   = AW - 7;
    localparam logic [HI_W-1:0] BASE_HI = HI_W'(BANK_BASE >> 7);

    logic win_hit;

    assign lat_idx = lat_addr[6:2];
    assign win_hit = (lat_addr[AW-1:7] == BASE_HI) && (lat_addr[1:0] == 2'b00);
    assign lat_hit = win_hit && ({1'b0, lat_idx} < (IDX_W+1)'(NREG));

    for (genvar i = 0; i < NIRQ; i++) begin : g_bit
        localparam int RI = i / WORD_W;
        localparam int BI = i % WORD_W;
        assign impl_mask[i]   = ext_enable && (IDX_W'(RI) <= range_cfg);
        assign access_mask[i] = impl_mask[i] && (sec_disable || lat_secure || !irq_secure[i]);
        assign clr_vec[i]     = apply && lat_hit && (lat_idx == IDX_W'(RI))
                                && lat_data[BI] && access_mask[i];
    end
endmodule

// File: rtl/pend_cell.sv
module pend_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic impl,
    input  logic level_mode,
    input  logic sig_in,
    input  logic set_req,
    input  logic clr_hit,
    input  logic act_req,
    input  logic deact_req,
    output logic pending,
    output logic active
);
    logic sw_q, act_q, sig_q;
    logic edge_evt, set_evt, pend_now, take;

    assign edge_evt = !level_mode && sig_in && !sig_q;
    assign set_evt  = set_req || edge_evt;
    assign pend_now = impl && (sw_q || (level_mode && sig_in));
    assign take     = act_req && pend_now;
    assign pending  = pend_now;
    assign active   = impl && act_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q  <= 1'b0;
            act_q <= 1'b0;
            sig_q <= 1'b0;
        end else begin
            sig_q <= sig_in;
            if (!impl) begin
                sw_q  <= 1'b0;
                act_q <= 1'b0;
            end else begin
                if (set_evt)             sw_q <= 1'b1;
                else if (clr_hit || take) sw_q <= 1'b0;
                if (take)           act_q <= 1'b1;
                else if (deact_req) act_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_pend_clear_bank.sv
module irq_pend_clear_bank
    import pend_clr_pkg::*;
#(
    parameter int NREG = 4,
    parameter int AW   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          bus_addr,
    input  logic [31:0]            bus_wdata,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic                   bus_secure,
    input  logic                   ext_enable,
    input  logic [4:0]             range_cfg,
    input  logic                   sec_disable,
    input  logic [NREG*32-1:0]     irq_level,
    input  logic [NREG*32-1:0]     irq_sig,
    input  logic [NREG*32-1:0]     irq_secure,
    input  logic [NREG*32-1:0]     set_pulse,
    input  logic [NREG*32-1:0]     act_pulse,
    input  logic [NREG*32-1:0]     deact_pulse,
    output logic                   rd_valid_o,
    output logic [31:0]            rd_data_o,
    output logic [NREG*32-1:0]     pending_o,
    output logic [NREG*32-1:0]     active_o
);
    localparam int NIRQ = NREG * WORD_W;
    localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1;

    bus_state_t          fsm_state;
    logic [AW-1:0]       lat_addr;
    logic [WORD_W-1:0]   lat_data;
    logic                lat_secure;
    logic [NIRQ-1:0]     impl_mask, access_mask, clr_vec;
    logic                lat_hit;
    logic [IDX_W-1:0]    lat_idx;
    logic [WORD_W-1:0]   word_view [NREG];
    logic [WORD_W-1:0]   rd_word;

    pend_bus_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
        .state_o(fsm_state), .lat_addr_o(lat_addr), .lat_data_o(lat_data),
        .lat_secure_o(lat_secure)
    );

    pend_decode #(.NREG(NREG), .AW(AW)) u_dec (
        .apply(fsm_state == ST_WR_APPLY), .lat_addr(lat_addr), .lat_data(lat_data),
        .lat_secure(lat_secure), .ext_enable(ext_enable), .range_cfg(range_cfg),
        .sec_disable(sec_disable), .irq_secure(irq_secure), .impl_mask(impl_mask),
        .access_mask(access_mask), .clr_vec(clr_vec), .lat_hit(lat_hit), .lat_idx(lat_idx)
    );

    for (genvar i = 0; i < NIRQ; i++) begin : g_cell
        pend_cell u_cell (
            .clk(clk), .rst_n(rst_n), .impl(impl_mask[i]), .level_mode(irq_level[i]),
            .sig_in(irq_sig[i]), .set_req(set_pulse[i]), .clr_hit(clr_vec[i]),
            .act_req(act_pulse[i]), .deact_req(deact_pulse[i]),
            .pending(pending_o[i]), .active(active_o[i])
        );
    end

    for (genvar r = 0; r < NREG; r++) begin : g_word
        assign word_view[r] = pending_o[r*WORD_W +: WORD_W] & access_mask[r*WORD_W +: WORD_W];
    end

    assign rd_word = lat_hit ? word_view[lat_idx[SELW-1:0]] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= (fsm_state == ST_RD_CAPTURE);
            rd_data_o  <= (fsm_state == ST_RD_CAPTURE) ? rd_word : '0;
        end
    end
endmodule

// File: rtl/irq_pend_clear_bank_chk.sv
module irq_pend_clear_bank_chk
    import pend_clr_pkg::*;
#(
    parameter int NREG = 4,
    parameter int AW   = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic                 sec_disable,
    input logic [NREG*32-1:0]   irq_level,
    input logic [NREG*32-1:0]   irq_sig,
    input logic [NREG*32-1:0]   irq_secure,
    input logic                 rd_valid_o,
    input logic [31:0]          rd_data_o,
    input logic [NREG*32-1:0]   pending_o,
    input logic [NREG*32-1:0]   active_o,
    input logic [NREG*32-1:0]   impl_mask,
    input bus_state_t           fsm_state,
    input logic                 lat_secure,
    input logic [4:0]           lat_idx
);
    logic [31:0] sec_word;
    always_comb sec_word = 32'(irq_secure >> (32 * int'(lat_idx)));

    // R10
    a_r10_reset_state: assert property (@(posedge clk)
        !rst_n |=> (active_o == '0 && !rd_valid_o));

    // R8
    a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && bus_rd && !bus_wr) |-> ##2 rd_valid_o);

    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);

    // R11
    a_r11_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != ST_IDLE) |=> (fsm_state == ST_IDLE));

    // R9
    a_r9_secure_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !$past(sec_disable) && !lat_secure) |-> ((rd_data_o & $past(sec_word)) == '0));

    // R5
    a_r5_level_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_level & irq_sig & impl_mask & ~pending_o) == '0));

    // R2
    a_r2_unimpl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (((pending_o | active_o) & ~impl_mask) == '0));

    // R6
    a_r6_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(irq_level) & $past(irq_sig) & ~$past(irq_sig, 2)
                   & $past(impl_mask) & impl_mask & ~pending_o) == '0));
endmodule

bind irq_pend_clear_bank irq_pend_clear_bank_chk #(.NREG(NREG), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .sec_disable(sec_disable), .irq_level(irq_level), .irq_sig(irq_sig),
    .irq_secure(irq_secure), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .pending_o(pending_o), .active_o(active_o), .impl_mask(impl_mask),
    .fsm_state(fsm_state), .lat_secure(lat_secure), .lat_idx(lat_idx)
);

// File: tb/irq_pend_clear_bank_tb.sv
module irq_pend_clear_bank_tb;
    localparam int NREG = 4;
    localparam int AW   = 16;
    localparam int NIRQ = NREG * 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, bus_secure = 1'b0;
    logic ext_enable = 1'b1, sec_disable = 1'b1;
    logic [4:0] range_cfg = 5'd3;
    logic [NIRQ-1:0] irq_level = '0, irq_sig = '0, irq_secure = '0;
    logic [NIRQ-1:0] set_pulse = '0, act_pulse = '0, deact_pulse = '0;
    logic rd_valid_o;
    logic [31:0] rd_data_o;
    logic [NIRQ-1:0] pending_o, active_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irq_pend_clear_bank #(.NREG(NREG), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_secure(bus_secure),
        .ext_enable(ext_enable), .range_cfg(range_cfg), .sec_disable(sec_disable),
        .irq_level(irq_level), .irq_sig(irq_sig), .irq_secure(irq_secure),
        .set_pulse(set_pulse), .act_pulse(act_pulse), .deact_pulse(deact_pulse),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .pending_o(pending_o), .active_o(active_o)
    );

    // Reference model built from the requirements
    logic [NIRQ-1:0] m_sw, m_act, m_sq;
    bit m_busy, m_wr_stage, m_wsec;
    logic [AW-1:0] m_waddr;
    logic [31:0] m_wdata;

    function automatic bit m_impl(int i);
        return ext_enable && ((i / 32) <= int'(range_cfg));
    endfunction
    function automatic bit m_acc(int i, bit sec);
        return m_impl(i) && (sec_disable || sec || !irq_secure[i]);
    endfunction
    function automatic bit m_hit(logic [AW-1:0] a);
        return (a[15:7] == 9'h030) && (a[1:0] == 2'b00) && (int'(a[6:2]) < NREG);
    endfunction
    function automatic bit m_pend(int i);
        return m_impl(i) && (m_sw[i] || (irq_level[i] && irq_sig[i]));
    endfunction
    function automatic logic [NIRQ-1:0] m_pend_vec();
        logic [NIRQ-1:0] v;
        for (int i = 0; i < NIRQ; i++) v[i] = m_pend(i);
        return v;
    endfunction
    function automatic logic [NIRQ-1:0] m_act_vec();
        logic [NIRQ-1:0] v;
        for (int i = 0; i < NIRQ; i++) v[i] = m_act[i] && m_impl(i);
        return v;
    endfunction
    function automatic logic [31:0] m_read(logic [AW-1:0] a, bit sec);
        logic [31:0] r = '0;
        if (m_hit(a))
            for (int b = 0; b < 32; b++) begin
                int k = int'(a[6:2]) * 32 + b;
                r[b] = m_pend(k) && m_acc(k, sec);
            end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sw = '0; m_act = '0; m_sq = '0;
            m_busy = 0; m_wr_stage = 0; m_wsec = 0; m_waddr = '0; m_wdata = '0;
        end else begin
            for (int i = 0; i < NIRQ; i++) begin
                bit im, pn, ev, cl, tk;
                im = m_impl(i);
                pn = m_pend(i);
                ev = set_pulse[i] || (!irq_level[i] && irq_sig[i] && !m_sq[i]);
                cl = m_wr_stage && m_hit(m_waddr) && (int'(m_waddr[6:2]) == i / 32)
                     && m_wdata[i % 32] && m_acc(i, m_wsec);
                tk = act_pulse[i] && pn;
                if (!im) begin
                    m_sw[i] = 0; m_act[i] = 0;
                end else begin
                    if (ev) m_sw[i] = 1;
                    else if (cl || tk) m_sw[i] = 0;
                    if (tk) m_act[i] = 1;
                    else if (deact_pulse[i]) m_act[i] = 0;
                end
                m_sq[i] = irq_sig[i];
            end
            if (m_busy) begin
                m_busy = 0; m_wr_stage = 0;
            end else if (bus_wr || bus_rd) begin
                m_busy = 1; m_wr_stage = bus_wr;
                m_waddr = bus_addr; m_wdata = bus_wdata; m_wsec = bus_secure;
            end
        end
    end

    task automatic chk(bit ok, string tag, logic [NIRQ-1:0] act, logic [NIRQ-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    bit rd_exp_due = 0, rd_chk = 0;
    logic [AW-1:0] rd_addr_q;
    bit rd_sec_q;
    logic [31:0] rd_exp;

    // One clock: inputs are already driven at this negedge
    task automatic tick();
        bit nxt_due = 0;
        logic [NIRQ-1:0] ep, ea;
        if (rd_exp_due) begin
            rd_exp = m_read(rd_addr_q, rd_sec_q);
            rd_exp_due = 0; rd_chk = 1;
        end
        if (!m_busy && bus_rd && !bus_wr) begin
            nxt_due = 1; rd_addr_q = bus_addr; rd_sec_q = bus_secure;
        end
        @(posedge clk);
        @(negedge clk);
        ep = m_pend_vec();
        ea = m_act_vec();
        chk(pending_o === ep, "R3 R4 R5 R6 R7 pending", pending_o, ep);
        chk(active_o === ea, "R12 active", active_o, ea);
        if (rd_chk)
            chk(rd_valid_o === 1'b1 && rd_data_o === rd_exp, "R8 R1 R9 read",
                NIRQ'({rd_valid_o, rd_data_o}), NIRQ'({1'b1, rd_exp}));
        else
            chk(rd_valid_o === 1'b0 && rd_data_o === '0, "R8 idle read port",
                NIRQ'({rd_valid_o, rd_data_o}), '0);
        rd_chk = 0;
        rd_exp_due = nxt_due;
        set_pulse = '0; act_pulse = '0; deact_pulse = '0;
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [31:0] d, bit sec);
        bus_wr = 1; bus_addr = a; bus_wdata = d; bus_secure = sec;
        tick();
        bus_wr = 0;
        tick();
    endtask

    task automatic do_read(logic [AW-1:0] a, bit sec);
        bus_rd = 1; bus_addr = a; bus_secure = sec;
        tick();
        bus_rd = 0;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (4) @(negedge clk);
        // R10 reset state
        chk(active_o === '0 && rd_valid_o === 1'b0, "R10 reset", active_o, '0);
        chk(pending_o === '0, "R10 reset pending", pending_o, '0);
        rst_n = 1;
        tick();
        chk(pending_o === '0 && active_o === '0, "R10 after release", pending_o, '0);

        // R5 level interrupt 5 stays pending through a clear
        irq_level[5] = 1; irq_sig[5] = 1;
        tick();
        chk(pending_o[5] === 1'b1, "R5 level high", NIRQ'(pending_o[5]), 1);
        do_write(16'h1800, 32'h20, 1);
        chk(pending_o[5] === 1'b1, "R5 clear under level", NIRQ'(pending_o[5]), 1);
        irq_sig[5] = 0;
        tick();
        chk(pending_o[5] === 1'b0, "R5 level dropped", NIRQ'(pending_o[5]), 0);
        set_pulse[5] = 1;
        tick();
        chk(pending_o[5] === 1'b1, "R6 level latched by set", NIRQ'(pending_o[5]), 1);
        do_write(16'h1800, 32'h20, 1);
        chk(pending_o[5] === 1'b0, "R4 level latch cleared", NIRQ'(pending_o[5]), 0);

        // R6 / R3 / R4 edge interrupt 40
        irq_sig[40] = 1;
        tick();
        chk(pending_o[40] === 1'b1, "R6 rising edge", NIRQ'(pending_o[40]), 1);
        do_write(16'h1804, 32'h0, 1);
        chk(pending_o[40] === 1'b1, "R3 zero write", NIRQ'(pending_o[40]), 1);
        do_write(16'h1804, 32'h100, 1);
        chk(pending_o[40] === 1'b0, "R4 edge cleared", NIRQ'(pending_o[40]), 0);

        // R7 clear and edge at the same edge
        set_pulse[41] = 1;
        tick();
        bus_wr = 1; bus_addr = 16'h1804; bus_wdata = 32'h200; bus_secure = 1;
        tick();
        bus_wr = 0; irq_sig[41] = 1;
        tick();
        chk(pending_o[41] === 1'b1, "R7 edge beats clear", NIRQ'(pending_o[41]), 1);

        // R12 / R4 active and pending
        set_pulse[70] = 1; tick();
        act_pulse[70] = 1; tick();
        chk(active_o[70] === 1'b1 && pending_o[70] === 1'b0, "R12 activate",
            NIRQ'({active_o[70], pending_o[70]}), 2);
        set_pulse[70] = 1; tick();
        do_write(16'h1808, 32'h40, 1);
        chk(active_o[70] === 1'b1 && pending_o[70] === 1'b0, "R4 active-pending to active",
            NIRQ'({active_o[70], pending_o[70]}), 2);
        deact_pulse[70] = 1; tick();
        chk(active_o[70] === 1'b0, "R12 deactivate", NIRQ'(active_o[70]), 0);
        act_pulse[71] = 1; tick();
        chk(active_o[71] === 1'b0, "R12 activate idle interrupt", NIRQ'(active_o[71]), 0);

        // R8 / R1 reads
        set_pulse[66] = 1; set_pulse[90] = 1; tick();
        do_read(16'h1808, 1);
        chk(rd_data_o === 32'h0400_0004, "R8 word read", NIRQ'(rd_data_o), NIRQ'(32'h0400_0004));
        do_read(16'h1810, 1);
        chk(rd_data_o === 32'h0, "R1 beyond bank", NIRQ'(rd_data_o), 0);
        do_read(16'h180A, 1);
        chk(rd_data_o === 32'h0, "R1 unaligned", NIRQ'(rd_data_o), 0);
        do_write(16'h1C08, 32'hFFFF_FFFF, 1);
        chk(pending_o[66] === 1'b1, "R1 outside window write", NIRQ'(pending_o[66]), 1);

        // R9 security masking
        sec_disable = 0; irq_secure[66] = 1; tick();
        do_read(16'h1808, 0);
        chk(rd_data_o === 32'h0400_0000, "R9 secure bit hidden", NIRQ'(rd_data_o), NIRQ'(32'h0400_0000));
        do_write(16'h1808, 32'h4, 0);
        chk(pending_o[66] === 1'b1, "R9 nonsecure write ignored", NIRQ'(pending_o[66]), 1);
        do_read(16'h1808, 1);
        chk(rd_data_o === 32'h0400_0004, "R9 secure read", NIRQ'(rd_data_o), NIRQ'(32'h0400_0004));
        do_write(16'h1808, 32'h4, 1);
        chk(pending_o[66] === 1'b0, "R9 secure write clears", NIRQ'(pending_o[66]), 0);
        sec_disable = 1;

        // R11 strobe while busy ignored
        set_pulse[0] = 1; tick();
        bus_rd = 1; bus_addr = 16'h1800; bus_secure = 1; tick();
        bus_rd = 0; bus_wr = 1; bus_wdata = 32'h1; tick();
        bus_wr = 0; tick(); tick();
        chk(pending_o[0] === 1'b1, "R11 busy strobe ignored", NIRQ'(pending_o[0]), 1);

        // R2 range and enable
        range_cfg = 5'd1; tick();
        do_read(16'h1808, 1);
        chk(rd_data_o === 32'h0 && pending_o[127:64] === '0, "R2 beyond range",
            NIRQ'(rd_data_o), 0);
        ext_enable = 0; tick();
        do_read(16'h1800, 1);
        chk(rd_data_o === 32'h0 && pending_o === '0, "R2 disabled", pending_o, '0);
        ext_enable = 1; range_cfg = 5'd3; tick();

        // Constrained random phases
        for (int ph = 0; ph < 6; ph++) begin
            for (int w = 0; w < NREG; w++) begin
                irq_level[w*32 +: 32]  = $urandom;
                irq_secure[w*32 +: 32] = $urandom;
            end
            sec_disable = $urandom % 2;
            range_cfg   = 5'($urandom % 5);
            ext_enable  = (ph != 3);
            tick(); tick();
            for (int c = 0; c < 500; c++) begin
                for (int w = 0; w < NREG; w++) begin
                    irq_sig[w*32 +: 32]     ^= $urandom & $urandom & $urandom;
                    set_pulse[w*32 +: 32]    = $urandom & $urandom & $urandom & $urandom;
                    act_pulse[w*32 +: 32]    = $urandom & $urandom & $urandom;
                    deact_pulse[w*32 +: 32]  = $urandom & $urandom & $urandom;
                end
                bus_wr = 0; bus_rd = 0;
                if (!m_busy && ($urandom % 3 == 0)) begin
                    bus_addr   = ($urandom % 8 == 0) ? 16'($urandom)
                                 : 16'(32'h1800 + 4 * ($urandom % 6));
                    bus_wdata  = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
                    bus_secure = $urandom % 2;
                    if ($urandom % 2 == 0) bus_wr = 1; else bus_rd = 1;
                end
                tick();
            end
            bus_wr = 0; bus_rd = 0;
            tick(); tick();
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule